// File: doc/BRIEF.md
# Two-Node Sharing-List Home Directory

This block is the home directory for one memory block that two processor caches share. Each node sends read, write-intent, flush and detach requests over a single valid/ready channel. The directory tracks the block in one of three states: uncached, shared-clean or exclusive/modified. It also keeps a pointer to the node at the head of the sharing list and one membership bit for each node. The directory does not hold a presence vector for every reader. When a second node reads a block that another node owns, the request goes to the current head, and that head supplies the data.

A request completes in one of two ways. It finishes at once with a registered response, or it opens a snoop: a forward or an invalidate goes to a node, and the directory waits for that node's reply. During a snoop the directory raises `busy` and drops `req_ready`. Write permission goes only to the head of the list. A node that shares the block behind the head must detach first and then ask again; its new request takes over the head pointer and invalidates the previous head. The block's memory copy is one internal register.

Top module: `lldir_ctrl`

## Requirements
- R1: After reset the directory state is uncached (`dir_state` 0), `busy` is 0, `req_ready` is 1, no response or snoop is valid, and the memory register holds zero.
- R2: A read (`req_op` 0) while uncached returns a read grant (`rsp_kind` 0) carrying the memory value, sets the state to exclusive/modified (`dir_state` 2) and makes the requester the head.
- R3: A read from a node outside the list while exclusive/modified sends a forward snoop (`snp_kind` 0) to the head and holds `busy`. The snoop reply's data goes to the reader in a read grant, is written to memory, sets the state to shared (`dir_state` 1) and makes the reader the new head.
- R4: A read from a node outside the list while shared returns the memory value in a read grant and makes that node the head. The state stays shared.
- R5: A write-intent (`req_op` 1) from the head gives a write grant (`rsp_kind` 1) and the exclusive/modified state. If the other node is still listed, an invalidate snoop (`snp_kind` 1) goes to that node first, and the grant follows its reply.
- R6: A write-intent from a listed node that is not the head gets a retry (`rsp_kind` 3), and the state and head stay unchanged.
- R7: A detach (`req_op` 3) from a listed non-head node returns an acknowledge (`rsp_kind` 2) and removes that node from the list. A detach from the head or from an unlisted node gets a retry.
- R8: A write-intent from an unlisted node while shared or exclusive/modified moves the head pointer to that node in the accept cycle and sends an invalidate to the previous head. After the reply it gets a write grant in exclusive/modified. The grant carries the reply data when the state was exclusive/modified, and the memory value when the state was shared.
- R9: A flush (`req_op` 2) from the head while exclusive/modified writes `req_data` into memory, sets the state to uncached and returns an acknowledge. Any other flush gets a retry and changes nothing.
- R10: While `busy` is high, `req_ready` is low and no request is consumed. A snoop reply that arrives while no snoop is open is ignored.
- R11: A write-intent while uncached returns an immediate write grant with the memory value, sets exclusive/modified and makes the requester the head.
- R12: A read from a node that is already listed gets a retry and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_node | input | 1 | Requesting node, 0 or 1 |
| req_op | input | 2 | 0 read, 1 write-intent, 2 flush, 3 detach |
| req_data | input | DATA_W | Flush data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_node | output | 1 | Node the response is for |
| rsp_kind | output | 2 | 0 read grant, 1 write grant, 2 acknowledge, 3 retry |
| rsp_data | output | DATA_W | Block data for grants |
| snp_valid | output | 1 | One-cycle snoop pulse |
| snp_node | output | 1 | Snooped node |
| snp_kind | output | 1 | 0 forward, 1 invalidate |
| snp_rsp_valid | input | 1 | Snoop reply from the snooped node |
| snp_rsp_data | input | DATA_W | Data returned with the reply |
| busy | output | 1 | A snoop is open |
| dir_state | output | 2 | 0 uncached, 1 shared, 2 exclusive/modified |
| head_node | output | 1 | Head-of-list pointer, meaningful in states 1 and 2 |

## Verification
The bench builds the directory with `DATA_W` set to 8. At that width each grant's data is a short literal, so the test can trace where a value came from: the memory register, a flush, or a snoop reply. Because the bench uses distinct byte values, it can tell memory data from forwarded data and can show that invalidate-reply data is dropped in the shared case. The bench holds a request against the busy window to show backpressure, and it resets mid-run to bring the memory register back to zero.

// File: rtl/lldir_pkg.sv
package lldir_pkg;
    typedef enum logic [1:0] {
        DIR_U  = 2'd0,
        DIR_S  = 2'd1,
        DIR_EM = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_FLUSH  = 2'd2,
        OP_DETACH = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RSP_RD    = 2'd0,
        RSP_WR    = 2'd1,
        RSP_ACK   = 2'd2,
        RSP_RETRY = 2'd3
    } rsp_e;

    typedef enum logic {
        SNP_FWD = 1'b0,
        SNP_INV = 1'b1
    } snp_e;
endpackage

// File: rtl/lldir_store.sv
module lldir_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign q = mem_q;
endmodule

// File: rtl/lldir_engine.sv
module lldir_engine
    import lldir_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_node,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    input  logic              snp_rsp_valid,
    input  logic [DATA_W-1:0] snp_rsp_data,
    input  logic [DATA_W-1:0] mem_q,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wd,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_node,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              snp_valid,
    output logic              snp_node,
    output logic              snp_kind,
    output logic [1:0]        dir_state,
    output logic              head_node
);
    typedef struct packed {
        dir_e              dir;
        logic              head;
        logic [1:0]        members;
        logic              busy;
        logic              pend_node;
        logic              pend_wr;
        logic              pend_upd;
        logic              rsp_valid;
        logic              rsp_node;
        rsp_e              rsp_kind;
        logic [DATA_W-1:0] rsp_data;
        logic              snp_valid;
        logic              snp_node;
        snp_e              snp_kind;
    } eng_t;

    eng_t st_d, st_q;

    logic       other;
    logic       listed;
    logic       is_head;
    logic [1:0] req_bit;
    logic [1:0] pend_bit;

    always_comb begin
        other    = ~req_node;
        listed   = st_q.members[req_node];
        is_head  = (st_q.dir != DIR_U) && (st_q.head == req_node);
        req_bit  = 2'b01 << req_node;
        pend_bit = 2'b01 << st_q.pend_node;

        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.snp_valid = 1'b0;
        mem_we         = 1'b0;
        mem_wd         = req_data;

        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_node  = req_node;
                st_d.rsp_kind  = RSP_RETRY;
                st_d.rsp_data  = mem_q;
                case (op_e'(req_op))
                    OP_READ: begin
                        if (!listed) begin
                            if (st_q.dir == DIR_EM) begin
                                st_d.rsp_valid = 1'b0;
                                st_d.snp_valid = 1'b1;
                                st_d.snp_node  = st_q.head;
                                st_d.snp_kind  = SNP_FWD;
                                st_d.busy      = 1'b1;
                                st_d.pend_node = req_node;
                                st_d.pend_wr   = 1'b0;
                                st_d.pend_upd  = 1'b1;
                            end else begin
                                st_d.rsp_kind = RSP_RD;
                                st_d.head     = req_node;
                                st_d.members  = st_q.members | req_bit;
                                if (st_q.dir == DIR_U) st_d.dir = DIR_EM;
                            end
                        end
                    end
                    OP_WRITE: begin
                        if (is_head && st_q.members[other]) begin
                            st_d.rsp_valid = 1'b0;
                            st_d.snp_valid = 1'b1;
                            st_d.snp_node  = other;
                            st_d.snp_kind  = SNP_INV;
                            st_d.busy      = 1'b1;
                            st_d.pend_node = req_node;
                            st_d.pend_wr   = 1'b1;
                            st_d.pend_upd  = 1'b0;
                        end else if (is_head || st_q.dir == DIR_U) begin
                            st_d.rsp_kind = RSP_WR;
                            st_d.dir      = DIR_EM;
                            st_d.head     = req_node;
                            st_d.members  = req_bit;
                        end else if (!listed) begin
                            st_d.rsp_valid = 1'b0;
                            st_d.snp_valid = 1'b1;
                            st_d.snp_node  = st_q.head;
                            st_d.snp_kind  = SNP_INV;
                            st_d.head      = req_node;
                            st_d.busy      = 1'b1;
                            st_d.pend_node = req_node;
                            st_d.pend_wr   = 1'b1;
                            st_d.pend_upd  = (st_q.dir == DIR_EM);
                        end
                    end
                    OP_FLUSH: begin
                        if (st_q.dir == DIR_EM && is_head) begin
                            mem_we        = 1'b1;
                            st_d.dir      = DIR_U;
                            st_d.members  = 2'b00;
                            st_d.rsp_kind = RSP_ACK;
                        end
                    end
                    OP_DETACH: begin
                        if (listed && !is_head) begin
                            st_d.members  = st_q.members & ~req_bit;
                            st_d.rsp_kind = RSP_ACK;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (snp_rsp_valid) begin
            st_d.busy      = 1'b0;
            st_d.rsp_valid = 1'b1;
            st_d.rsp_node  = st_q.pend_node;
            st_d.head      = st_q.pend_node;
            st_d.rsp_data  = st_q.pend_upd ? snp_rsp_data : mem_q;
            if (st_q.pend_upd) begin
                mem_we = 1'b1;
                mem_wd = snp_rsp_data;
            end
            if (st_q.pend_wr) begin
                st_d.rsp_kind = RSP_WR;
                st_d.dir      = DIR_EM;
                st_d.members  = pend_bit;
            end else begin
                st_d.rsp_kind = RSP_RD;
                st_d.dir      = DIR_S;
                st_d.members  = 2'b11;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_node  = st_q.rsp_node;
    assign rsp_kind  = st_q.rsp_kind;
    assign rsp_data  = st_q.rsp_data;
    assign snp_valid = st_q.snp_valid;
    assign snp_node  = st_q.snp_node;
    assign snp_kind  = st_q.snp_kind;
    assign dir_state = st_q.dir;
    assign head_node = st_q.head;
endmodule

// File: rtl/lldir_ctrl.sv
module lldir_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_node,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_node,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              snp_valid,
    output logic              snp_node,
    output logic              snp_kind,
    input  logic              snp_rsp_valid,
    input  logic [DATA_W-1:0] snp_rsp_data,
    output logic              busy,
    output logic [1:0]        dir_state,
    output logic              head_node
);
    logic              mem_we;
    logic [DATA_W-1:0] mem_wd;
    logic [DATA_W-1:0] mem_q;
    logic              busy_w;

    lldir_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wd    (mem_wd),
        .q     (mem_q)
    );

    lldir_engine #(.DATA_W(DATA_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_node      (req_node),
        .req_op        (req_op),
        .req_data      (req_data),
        .snp_rsp_valid (snp_rsp_valid),
        .snp_rsp_data  (snp_rsp_data),
        .mem_q         (mem_q),
        .mem_we        (mem_we),
        .mem_wd        (mem_wd),
        .busy          (busy_w),
        .rsp_valid     (rsp_valid),
        .rsp_node      (rsp_node),
        .rsp_kind      (rsp_kind),
        .rsp_data      (rsp_data),
        .snp_valid     (snp_valid),
        .snp_node      (snp_node),
        .snp_kind      (snp_kind),
        .dir_state     (dir_state),
        .head_node     (head_node)
    );

    assign busy      = busy_w;
    assign req_ready = ~busy_w;
endmodule

// File: rtl/lldir_ctrl_chk.sv
module lldir_ctrl_chk
    import lldir_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_node,
    input logic [1:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_node,
    input logic [1:0] rsp_kind,
    input logic       snp_valid,
    input logic       snp_node,
    input logic       snp_kind,
    input logic       snp_rsp_valid,
    input logic       busy,
    input logic [1:0] dir_state,
    input logic       head_node
);
    logic fire;
    assign fire = req_valid && req_ready;

    p_dir_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dir_state != 2'd3);

    p_read_u_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_READ && dir_state == DIR_U
        |=> rsp_valid && rsp_kind == RSP_RD && dir_state == DIR_EM
            && head_node == $past(req_node));

    p_fwd_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_READ && dir_state == DIR_EM && req_node != head_node
        |=> snp_valid && snp_kind == SNP_FWD && snp_node == $past(head_node) && busy);

    p_wr_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == RSP_WR |-> dir_state == DIR_EM && head_node == rsp_node);

    p_retry_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == RSP_RETRY |-> $stable(dir_state) && $stable(head_node));

    p_flush_u_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == OP_FLUSH && dir_state == DIR_EM && req_node == head_node
        |=> dir_state == DIR_U && rsp_valid && rsp_kind == RSP_ACK);

    p_snoop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> busy && !rsp_valid);

    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !snp_rsp_valid |=> busy && !rsp_valid);

    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);
endmodule

bind lldir_ctrl lldir_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_node      (req_node),
    .req_op        (req_op),
    .rsp_valid     (rsp_valid),
    .rsp_node      (rsp_node),
    .rsp_kind      (rsp_kind),
    .snp_valid     (snp_valid),
    .snp_node      (snp_node),
    .snp_kind      (snp_kind),
    .snp_rsp_valid (snp_rsp_valid),
    .busy          (busy),
    .dir_state     (dir_state),
    .head_node     (head_node)
);

// File: tb/lldir_ctrl_tb.sv
module lldir_ctrl_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_node = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid;
    logic          rsp_node;
    logic [1:0]    rsp_kind;
    logic [DW-1:0] rsp_data;
    logic          snp_valid;
    logic          snp_node;
    logic          snp_kind;
    logic          snp_rsp_valid = 1'b0;
    logic [DW-1:0] snp_rsp_data = '0;
    logic          busy;
    logic [1:0]    dir_state;
    logic          head_node;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lldir_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_op(req_op), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .snp_valid(snp_valid), .snp_node(snp_node), .snp_kind(snp_kind),
        .snp_rsp_valid(snp_rsp_valid), .snp_rsp_data(snp_rsp_data),
        .busy(busy), .dir_state(dir_state), .head_node(head_node)
    );

    typedef struct packed {
        logic       node;
        logic [1:0] op;
        logic [7:0] data;
        logic [1:0] kind;
        logic [7:0] edata;
        logic [1:0] st;
        logic       hd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 2'd2, 1'b0},  // R2 read while uncached
        '{1'b0, 2'd0, 8'h00, 2'd3, 8'h00, 2'd2, 1'b0},  // R12 listed reader retried
        '{1'b0, 2'd2, 8'hA5, 2'd2, 8'h00, 2'd0, 1'b0},  // R9 head flush
        '{1'b1, 2'd2, 8'h11, 2'd3, 8'h00, 2'd0, 1'b0},  // R9 flush while uncached
        '{1'b1, 2'd0, 8'h00, 2'd0, 8'hA5, 2'd2, 1'b1},  // R2 read returns flushed value
        '{1'b1, 2'd1, 8'h00, 2'd1, 8'hA5, 2'd2, 1'b1},  // R5 lone head write
        '{1'b1, 2'd2, 8'h5C, 2'd2, 8'h00, 2'd0, 1'b1},  // R9 flush again
        '{1'b0, 2'd1, 8'h00, 2'd1, 8'h5C, 2'd2, 1'b0},  // R11 write while uncached
        '{1'b1, 2'd3, 8'h00, 2'd3, 8'h00, 2'd2, 1'b0}   // R7 detach from unlisted
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic send(input logic n, input logic [1:0] op, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_node = n; req_op = op; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reply(input logic [DW-1:0] d);
        @(negedge clk);
        snp_rsp_valid = 1'b1; snp_rsp_data = d;
        @(negedge clk);
        snp_rsp_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic n, input logic [1:0] k,
                              input logic [DW-1:0] d, input logic [1:0] st, input logic hd);
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_node"}, int'(rsp_node), int'(n));
        chk({tag, " rsp_kind"}, int'(rsp_kind), int'(k));
        if (k < 2) chk({tag, " rsp_data"}, int'(rsp_data), int'(d));
        chk({tag, " dir_state"}, int'(dir_state), int'(st));
        if (st != 2'd0) chk({tag, " head_node"}, int'(head_node), int'(hd));
    endtask

    task automatic expect_snoop(input string tag, input logic n, input logic k);
        chk({tag, " snp_valid"}, int'(snp_valid), 1);
        chk({tag, " snp_node"}, int'(snp_node), int'(n));
        chk({tag, " snp_kind"}, int'(snp_kind), int'(k));
        chk({tag, " busy"}, int'(busy), 1);
        chk({tag, " req_ready"}, int'(req_ready), 0);
        chk({tag, " no rsp"}, int'(rsp_valid), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dir_state", int'(dir_state), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 snp_valid", int'(snp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].node, VECS[i].op, VECS[i].data[DW-1:0]);
            expect_rsp($sformatf("vec%0d", i), VECS[i].node, VECS[i].kind,
                       VECS[i].edata[DW-1:0], VECS[i].st, VECS[i].hd);
        end

        // R3 forwarded read; R10 a held request is not consumed while busy
        send(1'b1, 2'd0, 8'h00);
        expect_snoop("R3 fwd", 1'b0, 1'b0);
        req_valid = 1'b1; req_node = 1'b0; req_op = 2'd2; req_data = 8'hF0;
        @(negedge clk);
        chk("R10 held no rsp", int'(rsp_valid), 0);
        chk("R10 held busy", int'(busy), 1);
        @(negedge clk);
        chk("R10 held state", int'(dir_state), 2);
        req_valid = 1'b0;
        reply(8'h77);
        expect_rsp("R3 fwd grant", 1'b1, 2'd0, 8'h77, 2'd1, 1'b1);
        chk("R10 ready again", int'(req_ready), 1);

        // R6 listed non-head write
        send(1'b0, 2'd1, 8'h00);
        expect_rsp("R6 retry", 1'b0, 2'd3, 8'h00, 2'd1, 1'b1);
        // R7 detach listed non-head
        send(1'b0, 2'd3, 8'h00);
        expect_rsp("R7 detach", 1'b0, 2'd2, 8'h00, 2'd1, 1'b1);
        // R4 read in shared from unlisted, memory holds forwarded data (R3)
        send(1'b0, 2'd0, 8'h00);
        expect_rsp("R4 shared read", 1'b0, 2'd0, 8'h77, 2'd1, 1'b0);
        // R7 detach from head is refused
        send(1'b0, 2'd3, 8'h00);
        expect_rsp("R7 head detach", 1'b0, 2'd3, 8'h00, 2'd1, 1'b0);

        // R5 head write with other sharer listed
        send(1'b0, 2'd1, 8'h00);
        expect_snoop("R5 inv", 1'b1, 1'b1);
        chk("R5 head kept", int'(head_node), 0);
        reply(8'hEE);
        expect_rsp("R5 grant", 1'b0, 2'd1, 8'h77, 2'd2, 1'b0);

        // R8 unlisted write while exclusive/modified
        send(1'b1, 2'd1, 8'h00);
        expect_snoop("R8 inv em", 1'b0, 1'b1);
        chk("R8 head swapped", int'(head_node), 1);
        reply(8'h3C);
        expect_rsp("R8 grant em", 1'b1, 2'd1, 8'h3C, 2'd2, 1'b1);

        // R8 unlisted write while shared: reply data ignored
        send(1'b0, 2'd0, 8'h00);
        expect_snoop("R3 fwd2", 1'b1, 1'b0);
        reply(8'h42);
        expect_rsp("R3 fwd2 grant", 1'b0, 2'd0, 8'h42, 2'd1, 1'b0);
        send(1'b1, 2'd3, 8'h00);
        expect_rsp("R7 detach2", 1'b1, 2'd2, 8'h00, 2'd1, 1'b0);
        send(1'b1, 2'd1, 8'h00);
        expect_snoop("R8 inv s", 1'b0, 1'b1);
        chk("R8 head swapped s", int'(head_node), 1);
        reply(8'hDD);
        expect_rsp("R8 grant s", 1'b1, 2'd1, 8'h42, 2'd2, 1'b1);

        // R10 stray snoop reply while idle
        reply(8'h13);
        chk("R10 stray rsp", int'(rsp_valid), 0);
        chk("R10 stray busy", int'(busy), 0);
        chk("R10 stray state", int'(dir_state), 2);
        chk("R10 stray head", int'(head_node), 1);
        // R12 read from listed head
        send(1'b1, 2'd0, 8'h00);
        expect_rsp("R12 head read", 1'b1, 2'd3, 8'h00, 2'd2, 1'b1);
        // R9 non-head flush in EM refused, then head flush
        send(1'b0, 2'd2, 8'h99);
        expect_rsp("R9 nonhead flush", 1'b0, 2'd3, 8'h00, 2'd2, 1'b1);
        send(1'b1, 2'd2, 8'h6B);
        expect_rsp("R9 flush", 1'b1, 2'd2, 8'h00, 2'd0, 1'b0);
        send(1'b0, 2'd0, 8'h00);
        expect_rsp("R9 flushed data", 1'b0, 2'd0, 8'h6B, 2'd2, 1'b0);

        // R1 reset mid-run clears memory
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rerst dir_state", int'(dir_state), 0);
        chk("R1 rerst ready", int'(req_ready), 1);
        send(1'b1, 2'd0, 8'h00);
        expect_rsp("R1 memory zero", 1'b1, 2'd0, 8'h00, 2'd2, 1'b1);

        repeat (2) @(negedge clk);
        report();
    end
endmodule